// File: doc/BRIEF.md
# Receive Chunk Footer Builder with Host Interrupt

This block forms the 32-bit trailer word that a serial MAC-PHY device returns after each 64-byte receive payload. It takes the buffer occupancy counts (receive chunks waiting, transmit credits), a few status flags (extended status pending, bad header seen, configuration synchronized) and the framing description of the current receive chunk. It enforces the consistency rules between the framing fields, clamps the counts to the 5-bit fields, adds odd parity and registers the word when the shifter asks for it with a commit strobe.

The block also drives the interrupt line to the host. The interrupt works like an edge. It fires when a source that the last committed footer reported as empty becomes non-empty: no receive chunks, no transmit credits, or no extended status. It drops when the host's next data header arrives. After it has fired it stays quiet until another footer is committed. Until the first commit, every source counts as having been reported empty.

Top module: `rx_footer_irq`

## Requirements
- R1: Out of reset `footer_o` is 0x00000001. It loads a new value only on a clock edge where `commit_i` is high and holds it on every other edge.
- R2: Bit 31 carries `ext_stat_i`, bit 30 `hdr_bad_i` and bit 29 `cfg_sync_i`. Bits 23..22 are always 0.
- R3: Bits 28..24 carry `rx_chunks_i` and bits 5..1 carry `tx_credits_i`, each as an unsigned value. A value above 31 is clamped to 31.
- R4: Bit 21 (data valid) is `rx_valid_i & ~norx_i`. When it is 0, bits 20..6 are all 0.
- R5: Bit 20 (start) equals `rx_start_i` when data is valid. Bits 19..16 carry `rx_start_word_i` when bit 20 is 1 and are 0 otherwise.
- R6: Bit 14 (end) equals `rx_end_i` when data is valid. Bits 13..8 carry `rx_end_byte_i` when bit 14 is 1 and are 0 otherwise. Bit 15 (drop) is `rx_drop_i` only when bit 14 is 1, and 0 otherwise.
- R7: Bit 7 (timestamp added) is `rx_ts_added_i` only when bit 20 is 1. Bit 6 (timestamp parity) is `rx_ts_par_i` only when bit 7 is 1.
- R8: Bit 0 makes the number of ones in the 32-bit footer odd.
- R9: `irq_o` rises one cycle after any of these holds while the block is armed: the last committed footer had RCA = 0 and `rx_chunks_i` is non-zero; it had TXC = 0 and `tx_credits_i` is non-zero; or it had bit 31 = 0 and `ext_stat_i` is 1. A source that the last footer reported as non-empty raises nothing.
- R10: A cycle with `hdr_rx_i` high clears `irq_o` on the next edge, and this takes priority over a new set in the same cycle.
- R11: Once the interrupt has fired, it cannot fire again until a footer is committed, even while the condition persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_i | input | 1 | Register the footer for output this cycle |
| hdr_rx_i | input | 1 | A data header was received from the host |
| norx_i | input | 1 | Host refuses receive data for this chunk |
| rx_chunks_i | input | CNT_W | Receive chunks pending beyond the current one |
| tx_credits_i | input | CNT_W | Transmit chunks the host may still write |
| ext_stat_i | input | 1 | Unmasked extended status pending |
| hdr_bad_i | input | 1 | A header with bad parity was seen |
| cfg_sync_i | input | 1 | Configuration synchronized flag |
| rx_valid_i | input | 1 | Chunk carries receive frame data |
| rx_start_i | input | 1 | A frame starts in this chunk |
| rx_start_word_i | input | 4 | Word offset of the frame start |
| rx_end_i | input | 1 | A frame ends in this chunk |
| rx_end_byte_i | input | 6 | Byte offset of the last frame byte |
| rx_drop_i | input | 1 | The ending frame should be discarded |
| rx_ts_added_i | input | 1 | Timestamp prepended to the starting frame |
| rx_ts_par_i | input | 1 | Parity of that timestamp |
| footer_o | output | 32 | Registered footer word |
| irq_o | output | 1 | Interrupt to the host, active high |

## Verification
The framing fields are swept over every combination of the seven control flags at several start and end offsets. This separates the forcing caused by data-valid and no-receive from the start-only and end-only dependencies of the offset, drop and timestamp bits. A count sweep over the full input range exposes any error in clamping at or around 31. The status flags are swept separately to confirm their bit positions. For the interrupt, a scripted sequence drives each of the three sources from a footer that reported it empty and from one that reported it non-empty. The sequence also keeps a condition active after the clear to test that the interrupt does not fire again, and it lands a header on the same cycle as a new event to test that the clear wins.

// File: rtl/ftr_pkg.sv
package ftr_pkg;
  localparam int FTR_W     = 32;
  localparam int CNT_FLD_W = 5;
  localparam int SWO_W     = 4;
  localparam int EBO_W     = 6;

  // Field order matches the footer bit layout (bit 31 down to bit 1).
  typedef struct packed {
    logic                 exst;
    logic                 hdrb;
    logic                 sync;
    logic [CNT_FLD_W-1:0] rca;
    logic [1:0]           vend;
    logic                 dv;
    logic                 sv;
    logic [SWO_W-1:0]     swo;
    logic                 fd;
    logic                 ev;
    logic [EBO_W-1:0]     ebo;
    logic                 tsa;
    logic                 tsp;
    logic [CNT_FLD_W-1:0] txc;
  } ftr_body_t;
endpackage

// File: rtl/ftr_sat.sv
module ftr_sat #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 5
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int MAXV = (1 << OUT_W) - 1;

  generate
    if (IN_W > OUT_W) begin : g_clamp
      logic over;
      always_comb begin
        over  = (val_i > IN_W'(MAXV));
        val_o = over ? OUT_W'(MAXV) : val_i[OUT_W-1:0];
      end
    end else begin : g_pass
      always_comb val_o = OUT_W'(val_i);
    end
  endgenerate
endmodule

// File: rtl/ftr_rules.sv
module ftr_rules
  import ftr_pkg::*;
(
  input  logic             norx_i,
  input  logic             valid_i,
  input  logic             start_i,
  input  logic [SWO_W-1:0] swo_i,
  input  logic             end_i,
  input  logic [EBO_W-1:0] ebo_i,
  input  logic             drop_i,
  input  logic             tsa_i,
  input  logic             tsp_i,
  output logic             dv_o,
  output logic             sv_o,
  output logic [SWO_W-1:0] swo_o,
  output logic             fd_o,
  output logic             ev_o,
  output logic [EBO_W-1:0] ebo_o,
  output logic             tsa_o,
  output logic             tsp_o
);
  always_comb begin
    dv_o  = valid_i & ~norx_i;
    sv_o  = dv_o & start_i;
    ev_o  = dv_o & end_i;
    swo_o = sv_o ? swo_i : '0;
    ebo_o = ev_o ? ebo_i : '0;
    fd_o  = ev_o & drop_i;
    tsa_o = sv_o & tsa_i;
    tsp_o = tsa_o & tsp_i;
  end
endmodule

// File: rtl/ftr_irq.sv
module ftr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  input  logic hdr_rx_i,
  input  logic rca_nz_i,
  input  logic txc_nz_i,
  input  logic exst_i,
  input  logic snap_rca_zero_i,
  input  logic snap_txc_zero_i,
  input  logic snap_exst_zero_i,
  output logic irq_o
);
  logic pz_rca_q, pz_txc_q, pz_exst_q, armed_q, irq_q;
  logic pz_rca_d, pz_txc_d, pz_exst_d, armed_d, irq_d;
  logic event_hit;

  always_comb begin
    event_hit = (pz_rca_q & rca_nz_i) | (pz_txc_q & txc_nz_i) |
                (pz_exst_q & exst_i);
    pz_rca_d  = pz_rca_q;
    pz_txc_d  = pz_txc_q;
    pz_exst_d = pz_exst_q;
    if (commit_i) begin
      pz_rca_d  = snap_rca_zero_i;
      pz_txc_d  = snap_txc_zero_i;
      pz_exst_d = snap_exst_zero_i;
    end
    if (hdr_rx_i)                    irq_d = 1'b0;
    else if (event_hit && armed_q)   irq_d = 1'b1;
    else                             irq_d = irq_q;
    if (commit_i)                                armed_d = 1'b1;
    else if (event_hit && armed_q && !hdr_rx_i)  armed_d = 1'b0;
    else                                         armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pz_rca_q  <= 1'b1;
      pz_txc_q  <= 1'b1;
      pz_exst_q <= 1'b1;
      armed_q   <= 1'b1;
      irq_q     <= 1'b0;
    end else begin
      pz_rca_q  <= pz_rca_d;
      pz_txc_q  <= pz_txc_d;
      pz_exst_q <= pz_exst_d;
      armed_q   <= armed_d;
      irq_q     <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R10
  hdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_rx_i |=> !irq_o);

  // R11
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !armed_q && !commit_i) |=> !irq_o);
endmodule

// File: rtl/rx_footer_irq.sv
module rx_footer_irq
  import ftr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic             hdr_rx_i,
  input  logic             norx_i,
  input  logic [CNT_W-1:0] rx_chunks_i,
  input  logic [CNT_W-1:0] tx_credits_i,
  input  logic             ext_stat_i,
  input  logic             hdr_bad_i,
  input  logic             cfg_sync_i,
  input  logic             rx_valid_i,
  input  logic             rx_start_i,
  input  logic [3:0]       rx_start_word_i,
  input  logic             rx_end_i,
  input  logic [5:0]       rx_end_byte_i,
  input  logic             rx_drop_i,
  input  logic             rx_ts_added_i,
  input  logic             rx_ts_par_i,
  output logic [31:0]      footer_o,
  output logic             irq_o
);
  localparam int NCNT = 2;
  localparam logic [FTR_W-1:0] FTR_RST = FTR_W'(1);

  logic [CNT_W-1:0]     cnt_raw [NCNT];
  logic [CNT_FLD_W-1:0] cnt_sat [NCNT];
  logic                 cnt_nz  [NCNT];

  assign cnt_raw[0] = rx_chunks_i;
  assign cnt_raw[1] = tx_credits_i;

  genvar gi;
  generate
    for (gi = 0; gi < NCNT; gi++) begin : g_cnt
      ftr_sat #(.IN_W(CNT_W), .OUT_W(CNT_FLD_W)) u_sat (
        .val_i(cnt_raw[gi]),
        .val_o(cnt_sat[gi])
      );
      assign cnt_nz[gi] = |cnt_raw[gi];
    end
  endgenerate

  logic             f_dv, f_sv, f_fd, f_ev, f_tsa, f_tsp;
  logic [SWO_W-1:0] f_swo;
  logic [EBO_W-1:0] f_ebo;

  ftr_rules u_rules (
    .norx_i (norx_i),
    .valid_i(rx_valid_i),
    .start_i(rx_start_i),
    .swo_i  (rx_start_word_i),
    .end_i  (rx_end_i),
    .ebo_i  (rx_end_byte_i),
    .drop_i (rx_drop_i),
    .tsa_i  (rx_ts_added_i),
    .tsp_i  (rx_ts_par_i),
    .dv_o   (f_dv),
    .sv_o   (f_sv),
    .swo_o  (f_swo),
    .fd_o   (f_fd),
    .ev_o   (f_ev),
    .ebo_o  (f_ebo),
    .tsa_o  (f_tsa),
    .tsp_o  (f_tsp)
  );

  ftr_body_t        body;
  logic             par_bit;
  logic [FTR_W-1:0] ftr_d, ftr_q;

  always_comb begin
    body.exst = ext_stat_i;
    body.hdrb = hdr_bad_i;
    body.sync = cfg_sync_i;
    body.rca  = cnt_sat[0];
    body.vend = 2'b00;
    body.dv   = f_dv;
    body.sv   = f_sv;
    body.swo  = f_swo;
    body.fd   = f_fd;
    body.ev   = f_ev;
    body.ebo  = f_ebo;
    body.tsa  = f_tsa;
    body.tsp  = f_tsp;
    body.txc  = cnt_sat[1];
    par_bit   = ~(^body);
    ftr_d     = commit_i ? {body, par_bit} : ftr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ftr_q <= FTR_RST;
    else        ftr_q <= ftr_d;
  end

  assign footer_o = ftr_q;

  ftr_irq u_irq (
    .clk             (clk),
    .rst_n           (rst_n),
    .commit_i        (commit_i),
    .hdr_rx_i        (hdr_rx_i),
    .rca_nz_i        (cnt_nz[0]),
    .txc_nz_i        (cnt_nz[1]),
    .exst_i          (ext_stat_i),
    .snap_rca_zero_i (~|cnt_sat[0]),
    .snap_txc_zero_i (~|cnt_sat[1]),
    .snap_exst_zero_i(~ext_stat_i),
    .irq_o           (irq_o)
  );

  // R1
  footer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(footer_o));

  // R8
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(footer_o) % 2 == 1);

  // R5
  swo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !footer_o[20] |-> footer_o[19:16] == 4'd0);

  // R6
  fd_needs_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    footer_o[15] |-> footer_o[14]);

  // R3
  rca_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && (32'(rx_chunks_i) >= 32'd31)) |=> footer_o[28:24] == 5'd31);
endmodule

// File: tb/rx_footer_irq_test.sv
`timescale 1ns/1ps
module rx_footer_irq_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic commit_i = 0, hdr_rx_i = 0, norx_i = 0;
  logic [CNT_W-1:0] rx_chunks_i = '0, tx_credits_i = '0;
  logic ext_stat_i = 0, hdr_bad_i = 0, cfg_sync_i = 0;
  logic rx_valid_i = 0, rx_start_i = 0, rx_end_i = 0, rx_drop_i = 0;
  logic [3:0] rx_start_word_i = '0;
  logic [5:0] rx_end_byte_i = '0;
  logic rx_ts_added_i = 0, rx_ts_par_i = 0;
  logic [31:0] footer_o;
  logic irq_o;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_footer_irq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .hdr_rx_i(hdr_rx_i),
    .norx_i(norx_i), .rx_chunks_i(rx_chunks_i), .tx_credits_i(tx_credits_i),
    .ext_stat_i(ext_stat_i), .hdr_bad_i(hdr_bad_i), .cfg_sync_i(cfg_sync_i),
    .rx_valid_i(rx_valid_i), .rx_start_i(rx_start_i),
    .rx_start_word_i(rx_start_word_i), .rx_end_i(rx_end_i),
    .rx_end_byte_i(rx_end_byte_i), .rx_drop_i(rx_drop_i),
    .rx_ts_added_i(rx_ts_added_i), .rx_ts_par_i(rx_ts_par_i),
    .footer_o(footer_o), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Expected footer built arithmetically from the requirement text.
  function automatic logic [31:0] model();
    int rca, txc, dv, sv, ev, swo, ebo, fd, ta, tp, ones;
    logic [31:0] w;
    rca = (int'(rx_chunks_i) > 31) ? 31 : int'(rx_chunks_i);
    txc = (int'(tx_credits_i) > 31) ? 31 : int'(tx_credits_i);
    dv  = (rx_valid_i && !norx_i) ? 1 : 0;
    sv  = (dv == 1 && rx_start_i) ? 1 : 0;
    ev  = (dv == 1 && rx_end_i) ? 1 : 0;
    swo = sv * int'(rx_start_word_i);
    ebo = ev * int'(rx_end_byte_i);
    fd  = ev * int'(rx_drop_i);
    ta  = sv * int'(rx_ts_added_i);
    tp  = ta * int'(rx_ts_par_i);
    w = 32'(int'(ext_stat_i)) * 32'h8000_0000 + 32'(int'(hdr_bad_i)) * 32'h4000_0000
      + 32'(int'(cfg_sync_i)) * 32'h2000_0000 + 32'(rca) * 32'h0100_0000
      + 32'(dv) * 32'h0020_0000 + 32'(sv) * 32'h0010_0000 + 32'(swo) * 32'h0001_0000
      + 32'(fd) * 32'h8000 + 32'(ev) * 32'h4000 + 32'(ebo) * 32'h100
      + 32'(ta) * 32'h80 + 32'(tp) * 32'h40 + 32'(txc) * 2;
    ones = 0;
    for (int b = 0; b < 32; b++) ones += int'(w[b]);
    if (ones % 2 == 0) w = w + 1;
    return w;
  endfunction

  task automatic commit_check(string tag);
    logic [31:0] exp;
    exp = model();
    commit_i = 1'b1;
    @(negedge clk);
    commit_i = 1'b0;
    check(tag, footer_o, exp);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_commit();
    commit_i = 1'b1;
    @(negedge clk);
    commit_i = 1'b0;
  endtask

  task automatic hdr_pulse();
    hdr_rx_i = 1'b1;
    @(negedge clk);
    hdr_rx_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    step(3);
    check("R1 reset footer", footer_o, 32'h1);
    check("R9 reset irq", {31'd0, irq_o}, 32'd0);
    rst_n = 1'b1;
    step(2);
    check("R9 idle irq", {31'd0, irq_o}, 32'd0);

    // Receive source from empty-since-reset
    rx_chunks_i = 8'd3;
    @(negedge clk);
    check("R9 rca rise", {31'd0, irq_o}, 32'd1);
    hdr_pulse();
    check("R10 clear", {31'd0, irq_o}, 32'd0);
    step(3);
    check("R11 no refire", {31'd0, irq_o}, 32'd0);

    // Commit with rca nonzero: source no longer empty
    do_commit();
    step(2);
    check("R9 prior nonempty", {31'd0, irq_o}, 32'd0);

    tx_credits_i = 8'd5;
    @(negedge clk);
    check("R9 txc rise", {31'd0, irq_o}, 32'd1);
    hdr_pulse();
    check("R10 clear txc", {31'd0, irq_o}, 32'd0);

    do_commit();
    ext_stat_i = 1'b1;
    @(negedge clk);
    check("R9 exst rise", {31'd0, irq_o}, 32'd1);
    hdr_pulse();
    check("R10 clear exst", {31'd0, irq_o}, 32'd0);

    // Header and new event in the same cycle
    rx_chunks_i = 8'd0;
    do_commit();
    step(1);
    check("R9 quiet after commit", {31'd0, irq_o}, 32'd0);
    rx_chunks_i = 8'd2;
    hdr_rx_i = 1'b1;
    @(negedge clk);
    hdr_rx_i = 1'b0;
    check("R10 clear wins", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    check("R9 set after header", {31'd0, irq_o}, 32'd1);
    hdr_pulse();
    ext_stat_i = 1'b0;

    // R1: footer holds without commit
    commit_check("R1 load");
    held = footer_o;
    rx_chunks_i = 8'd17; hdr_bad_i = 1'b1; rx_valid_i = 1'b1;
    step(3);
    check("R1 hold", footer_o, held);
    rx_valid_i = 1'b0; hdr_bad_i = 1'b0;

    // R2: status bits, vendor bits zero
    for (int s = 0; s < 8; s++) begin
      ext_stat_i = s[0]; hdr_bad_i = s[1]; cfg_sync_i = s[2];
      commit_check("R2 status");
      check("R2 vendor zero", {30'd0, footer_o[23:22]}, 32'd0);
    end
    ext_stat_i = 0; hdr_bad_i = 0; cfg_sync_i = 0;

    // R3: full count sweep
    for (int c = 0; c < 256; c++) begin
      rx_chunks_i  = 8'(c);
      tx_credits_i = 8'((c * 7 + 3) % 256);
      commit_check("R3 R8 counts");
    end

    // R4..R8: all framing flag combinations
    for (int f = 0; f < 128; f++) begin
      for (int o = 0; o < 3; o++) begin
        rx_valid_i    = f[0];
        rx_start_i    = f[1];
        rx_end_i      = f[2];
        rx_drop_i     = f[3];
        rx_ts_added_i = f[4];
        rx_ts_par_i   = f[5];
        norx_i        = f[6];
        rx_start_word_i = (o == 0) ? 4'd0 : (o == 1) ? 4'd5 : 4'd15;
        rx_end_byte_i   = (o == 0) ? 6'd0 : (o == 1) ? 6'd37 : 6'd63;
        rx_chunks_i  = 8'(f);
        tx_credits_i = 8'(o * 11);
        commit_check("R4 R5 R6 R7 R8 framing");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule